// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block buffers 18-bit words between two unrelated clock domains. A producer pushes words on its own clock with a write enable, and a consumer pulls them on a separate read clock with a read enable. The read data sits in a register behind an output enable. When that enable is low, the register drives high impedance onto the bus.

Status is reported as five flags:

- empty and full;
- a half-full indication;
- two threshold flags, almost-empty and almost-full.

The two thresholds are set at run time. A program strobe on the write side copies the low 16 bits of the data input into one of two offset registers. The first program write goes to the empty-side offset, the next one to the full-side offset, and after that the two alternate. A mode input picks how the threshold flags are produced. They are either decoded straight from each side's occupancy, or passed through one extra register clocked by that side's own clock.

A rewind input on the read side moves the read position back to the first word written since reset, so the same data can be read out again. Pointers cross between the domains as Gray code through two-stage synchronizers.

Top module: `dualclk_fifo`

## Requirements
- R1: On a write-clock rising edge with wrEn high, loadEn low and fullFlag low, dataIn is stored. Words leave in the order they were stored, and all 18 bits are kept.
- R2: On a read-clock rising edge with rdEn high, emptyFlag low and retransmit low, the oldest word is loaded into the output register and appears on dataOut right after that edge. A read while empty leaves dataOut and the read position unchanged.
- R3: fullFlag is high when DEPTH words are stored. A write while full is ignored: the word never appears at the output.
- R4: emptyFlag is high when no word is stored. halfFlag is high when more than DEPTH/2 words are stored.
- R5: dataOut is high impedance whenever outEn is low.
- R6: Reset sets both offsets to 127. A cycle with loadEn high copies dataIn[15:0] into the empty-side offset on the first such cycle, into the full-side offset on the second, and alternates after that. These cycles store no data word.
- R7: almostFull is high when the stored count plus the full-side offset is at least DEPTH. almostEmpty is high when the stored count is at or below the empty-side offset.
- R8: With syncMode low, the threshold flags follow the count with no added register: almostFull changes right after the write edge that changes the count. With syncMode high, each threshold flag is registered on its own side's clock and lags by one more edge.
- R9: retransmit, sampled on a read-clock edge, returns the read position to the first word stored since reset. The full contents can then be read again in order, provided no more than DEPTH words have been written since reset.
- R10: An active-low reset clears both pointers and the output register. It sets emptyFlag high, and fullFlag and halfFlag low.
- R11: The Gray-coded write pointer changes in at most one bit per write-clock edge. The Gray-coded read pointer does the same, except on a rewind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wrClk | input | 1 | Write-side clock |
| wrEn | input | 1 | Write enable |
| loadEn | input | 1 | Program strobe: loads an offset instead of storing a word |
| dataIn | input | 18 | Write data; bits 15:0 also carry offsets |
| rdClk | input | 1 | Read-side clock |
| rdEn | input | 1 | Read enable |
| retransmit | input | 1 | Rewinds the read position to the start |
| outEn | input | 1 | Output enable; low gives high impedance |
| syncMode | input | 1 | 1 = threshold flags registered on their own clocks |
| dataOut | output | 18 | Read data, tri-stated by outEn |
| emptyFlag | output | 1 | No stored words (read domain) |
| fullFlag | output | 1 | DEPTH stored words (write domain) |
| halfFlag | output | 1 | More than DEPTH/2 stored words (write domain) |
| almostEmpty | output | 1 | Count at or below the empty-side offset (read domain) |
| almostFull | output | 1 | Count plus the full-side offset at least DEPTH (write domain) |

## Verification
The FIFO is filled one word at a time from empty to full. After each step the five flags are compared with values worked out from that step's occupancy. This sweep separates the strict half-full threshold from the inclusive threshold flags, and the default offsets from the programmed ones.

Draining with a distinct pattern per word exposes any reordering or lost bits. An extra write while full shows whether an overflow word leaks out, and an extra read while empty shows whether the output register moves. The same threshold crossing is sampled right after its write edge in both flag modes, which tells the decoded path from the registered one. A partial read followed by a rewind shows whether reading restarts at the first word.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  // Strobes from control to storage: one per clock domain.
  typedef struct packed {
    logic push;  // write domain: store dataIn at wrAddr
    logic pop;   // read domain: load output register from rdAddr
  } strobe_t;
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/dcf_ctrl.sv
`timescale 1ns/1ps
module dcf_ctrl
  import dcf_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int OFF_W   = 16,
  parameter int DEF_OFF = 127
) (
  input  logic                     rstN,
  input  logic                     wrClk,
  input  logic                     wrEn,
  input  logic                     loadEn,
  input  logic [OFF_W-1:0]         loadData,
  input  logic                     rdClk,
  input  logic                     rdEn,
  input  logic                     retransmit,
  input  logic                     syncMode,
  output strobe_t                  strobes,
  output logic [$clog2(DEPTH)-1:0] wrAddr,
  output logic [$clog2(DEPTH)-1:0] rdAddr,
  output logic                     emptyFlag,
  output logic                     fullFlag,
  output logic                     halfFlag,
  output logic                     almostEmpty,
  output logic                     almostFull
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PTR_W  = ADDR_W + 1;
  localparam int EXT_W  = OFF_W + 1;

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] toBin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PTR_W-1:0] wrBin, wrGray, rdBin, rdGray;
  logic [PTR_W-1:0] wrGraySync, rdGraySync;
  logic [PTR_W-1:0] wrCount, rdCount;
  logic [OFF_W-1:0] emptyOff, fullOff;
  logic             offSel;
  logic             afNow, aeNow, afReg, aeReg;

  assign strobes.push = wrEn && !loadEn && !fullFlag;
  assign strobes.pop  = rdEn && !emptyFlag && !retransmit;
  assign wrAddr = wrBin[ADDR_W-1:0];
  assign rdAddr = rdBin[ADDR_W-1:0];

  // Write side: pointer and offset registers.
  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (strobes.push) begin
      wrBin  <= wrBin + 1'b1;
      wrGray <= toGray(wrBin + 1'b1);
    end
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      emptyOff <= OFF_W'(DEF_OFF);
      fullOff  <= OFF_W'(DEF_OFF);
      offSel   <= 1'b0;
    end else if (loadEn) begin
      if (!offSel) emptyOff <= loadData;
      else         fullOff  <= loadData;
      offSel <= ~offSel;
    end
  end

  // Read side: pointer with rewind.
  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (retransmit) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (strobes.pop) begin
      rdBin  <= rdBin + 1'b1;
      rdGray <= toGray(rdBin + 1'b1);
    end
  end

  // Gray pointers cross into the opposite domain.
  dcf_sync #(.WIDTH(PTR_W)) uRdToWr (
    .clk(wrClk), .rstN(rstN), .asyncIn(rdGray), .syncOut(rdGraySync)
  );
  dcf_sync #(.WIDTH(PTR_W)) uWrToRd (
    .clk(rdClk), .rstN(rstN), .asyncIn(wrGray), .syncOut(wrGraySync)
  );

  assign wrCount = wrBin - toBin(rdGraySync);
  assign rdCount = toBin(wrGraySync) - rdBin;

  assign fullFlag  = (wrCount == PTR_W'(DEPTH));
  assign halfFlag  = (wrCount > PTR_W'(DEPTH / 2));
  assign emptyFlag = (rdCount == '0);

  assign afNow = ({{(EXT_W-PTR_W){1'b0}}, wrCount} + {1'b0, fullOff}) >= EXT_W'(DEPTH);
  assign aeNow = {{(OFF_W-PTR_W){1'b0}}, rdCount} <= emptyOff;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) afReg <= 1'b0;
    else       afReg <= afNow;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) aeReg <= 1'b1;
    else       aeReg <= aeNow;
  end

  assign almostFull  = syncMode ? afReg : afNow;
  assign almostEmpty = syncMode ? aeReg : aeNow;

  // R3: the write pointer holds while full.
  a_r3_hold_when_full: assert property (@(posedge wrClk) disable iff (!rstN)
    fullFlag |=> $stable(wrBin));
  // R4: the write-side occupancy never exceeds the depth.
  a_r4_count_bound: assert property (@(posedge wrClk) disable iff (!rstN)
    wrCount <= PTR_W'(DEPTH));
  // R2: the read pointer holds while empty (except on rewind).
  a_r2_hold_when_empty: assert property (@(posedge rdClk) disable iff (!rstN)
    (emptyFlag && !retransmit) |=> $stable(rdBin));
  // R11: the write Gray pointer moves by at most one bit.
  a_r11_wr_gray_step: assert property (@(posedge wrClk) disable iff (!rstN)
    1'b1 |=> $onehot0(wrGray ^ $past(wrGray)));
  // R11: the read Gray pointer moves by at most one bit outside a rewind.
  a_r11_rd_gray_step: assert property (@(posedge rdClk) disable iff (!rstN)
    !retransmit |=> $onehot0(rdGray ^ $past(rdGray)));
endmodule

// File: rtl/dcf_data.sv
`timescale 1ns/1ps
module dcf_data
  import dcf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 18
) (
  input  logic                     rstN,
  input  logic                     wrClk,
  input  logic                     rdClk,
  input  strobe_t                  strobes,
  input  logic [$clog2(DEPTH)-1:0] wrAddr,
  input  logic [$clog2(DEPTH)-1:0] rdAddr,
  input  logic [DATA_W-1:0]        dataIn,
  input  logic                     outEn,
  output logic [DATA_W-1:0]        dataOut
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] dataReg;

  always_ff @(posedge wrClk) begin
    if (strobes.push) mem[wrAddr] <= dataIn;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)            dataReg <= '0;
    else if (strobes.pop) dataReg <= mem[rdAddr];
  end

  assign dataOut = outEn ? dataReg : {DATA_W{1'bz}};
endmodule

// File: rtl/dualclk_fifo.sv
`timescale 1ns/1ps
module dualclk_fifo
  import dcf_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int DATA_W  = 18,
  parameter int OFF_W   = 16,
  parameter int DEF_OFF = 127
) (
  input  logic              rstN,
  input  logic              wrClk,
  input  logic              wrEn,
  input  logic              loadEn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              rdClk,
  input  logic              rdEn,
  input  logic              retransmit,
  input  logic              outEn,
  input  logic              syncMode,
  output logic [DATA_W-1:0] dataOut,
  output logic              emptyFlag,
  output logic              fullFlag,
  output logic              halfFlag,
  output logic              almostEmpty,
  output logic              almostFull
);
  localparam int ADDR_W = $clog2(DEPTH);

  strobe_t           strobes;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  dcf_ctrl #(.DEPTH(DEPTH), .OFF_W(OFF_W), .DEF_OFF(DEF_OFF)) uCtrl (
    .rstN(rstN), .wrClk(wrClk), .wrEn(wrEn), .loadEn(loadEn),
    .loadData(dataIn[OFF_W-1:0]), .rdClk(rdClk), .rdEn(rdEn),
    .retransmit(retransmit), .syncMode(syncMode), .strobes(strobes),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .emptyFlag(emptyFlag),
    .fullFlag(fullFlag), .halfFlag(halfFlag), .almostEmpty(almostEmpty),
    .almostFull(almostFull)
  );

  dcf_data #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uData (
    .rstN(rstN), .wrClk(wrClk), .rdClk(rdClk), .strobes(strobes),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .dataIn(dataIn), .outEn(outEn),
    .dataOut(dataOut)
  );
endmodule

// File: tb/dualclk_fifo_test.sv
`timescale 1ns/1ps
module dualclk_fifo_test;
  localparam int DEPTH = 16;
  localparam int DW    = 18;

  logic rstN = 1'b0, wrClk = 1'b0, rdClk = 1'b0;
  logic wrEn = 0, loadEn = 0, rdEn = 0, retransmit = 0, outEn = 0, syncMode = 0;
  logic [DW-1:0] dataIn = '0;
  wire  [DW-1:0] dataOut;
  logic emptyFlag, fullFlag, halfFlag, almostEmpty, almostFull;

  int checks = 0, errors = 0;
  int eOff = 127, fOff = 127;
  bit finished = 0;

  always #2.5 wrClk = ~wrClk;
  always #3.5 rdClk = ~rdClk;

  dualclk_fifo uut (
    .rstN(rstN), .wrClk(wrClk), .wrEn(wrEn), .loadEn(loadEn), .dataIn(dataIn),
    .rdClk(rdClk), .rdEn(rdEn), .retransmit(retransmit), .outEn(outEn),
    .syncMode(syncMode), .dataOut(dataOut), .emptyFlag(emptyFlag),
    .fullFlag(fullFlag), .halfFlag(halfFlag), .almostEmpty(almostEmpty),
    .almostFull(almostFull)
  );

  function automatic logic [DW-1:0] pat(input int i);
    return DW'((i * 7919 + 5) ^ 18'h15A5A);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge rdClk);
    repeat (4) @(posedge wrClk);
    #1;
  endtask

  task automatic flagsExpect(input int n);
    check("R4 empty", 32'(emptyFlag), 32'(n == 0));
    check("R3 full", 32'(fullFlag), 32'(n == DEPTH));
    check("R4 half", 32'(halfFlag), 32'(n > DEPTH / 2));
    check("R7 almostEmpty", 32'(almostEmpty), 32'(n <= eOff));
    check("R7 almostFull", 32'(almostFull), 32'(n + fOff >= DEPTH));
  endtask

  task automatic doWrite(input logic [DW-1:0] d, output logic afSnap);
    @(negedge wrClk); wrEn = 1; dataIn = d;
    @(posedge wrClk); #1; afSnap = almostFull;
    @(negedge wrClk); wrEn = 0;
  endtask

  task automatic doLoad(input int v);
    @(negedge wrClk); loadEn = 1; dataIn = DW'(v);
    @(negedge wrClk); loadEn = 0;
  endtask

  task automatic doRead(output logic [DW-1:0] got);
    @(negedge rdClk); rdEn = 1;
    @(posedge rdClk); #1; got = dataOut;
    @(negedge rdClk); rdEn = 0;
  endtask

  task automatic doReset();
    @(negedge wrClk); rstN = 0; eOff = 127; fOff = 127;
    #20; rstN = 1;
    settle();
  endtask

  initial begin
    #300000;
    errors++;
    $display("FAIL watchdog expired");
    if (!finished) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic snap;
    logic [DW-1:0] got;
    #23 rstN = 1;
    settle();
    // R10 reset state, R6 default offsets, R5 high impedance
    check("R10 empty", 32'(emptyFlag), 1);
    check("R10 full", 32'(fullFlag), 0);
    check("R10 half", 32'(halfFlag), 0);
    check("R6 default aE", 32'(almostEmpty), 1);
    check("R6 default aF", 32'(almostFull), 1);
    check("R5 hiZ", 32'(dataOut === {DW{1'bz}}), 1);

    // R6 program the two offsets in sequence; no data stored
    doLoad(3); doLoad(4); eOff = 3; fOff = 4;
    settle();
    flagsExpect(0);

    // R1/R3/R4/R7/R8 fill sweep, syncMode low
    for (int n = 1; n <= DEPTH; n++) begin
      doWrite(pat(n - 1), snap);
      if (n == DEPTH - fOff) check("R8 decoded aF immediate", 32'(snap), 1);
      settle();
      flagsExpect(n);
    end
    // R3 write while full is dropped
    doWrite(pat(99), snap);
    settle();
    flagsExpect(DEPTH);

    outEn = 1; #1;
    check("R10 output register cleared", 32'(dataOut), 0);
    // R1/R2 drain and order
    for (int i = 0; i < DEPTH; i++) begin
      doRead(got);
      check("R1 R2 read data", 32'(got), 32'(pat(i)));
      settle();
      flagsExpect(DEPTH - 1 - i);
    end
    // R2 read while empty leaves output; R3 overflow word never appears
    doRead(got);
    check("R2 R3 empty read holds", 32'(got), 32'(pat(DEPTH - 1)));
    settle();
    flagsExpect(0);
    outEn = 0; #1;
    check("R5 hiZ again", 32'(dataOut === {DW{1'bz}}), 1);

    // R6 reset restores defaults
    doReset();
    flagsExpect(0);

    // R8 registered flag lags one write edge
    syncMode = 1;
    doLoad(3); doLoad(4); eOff = 3; fOff = 4;
    settle();
    flagsExpect(0);
    for (int i = 0; i < DEPTH - fOff - 1; i++) doWrite(pat(100 + i), snap);
    settle();
    flagsExpect(DEPTH - fOff - 1);
    doWrite(pat(100 + DEPTH - fOff - 1), snap);
    check("R8 registered aF not yet", 32'(snap), 0);
    @(posedge wrClk); #1;
    check("R8 registered aF one edge later", 32'(almostFull), 1);
    settle();
    flagsExpect(DEPTH - fOff);

    // R9 partial read, rewind, full re-read
    outEn = 1;
    for (int i = 0; i < 3; i++) begin
      doRead(got);
      check("R9 pre-rewind read", 32'(got), 32'(pat(100 + i)));
    end
    settle();
    flagsExpect(DEPTH - fOff - 3);
    @(negedge rdClk); retransmit = 1;
    @(negedge rdClk); retransmit = 0;
    settle();
    flagsExpect(DEPTH - fOff);
    for (int i = 0; i < DEPTH - fOff; i++) begin
      doRead(got);
      check("R9 re-read data", 32'(got), 32'(pat(100 + i)));
    end
    settle();
    flagsExpect(0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule